// File: doc/BRIEF.md
# Two-Wire Bus Multiplexer Channel Connection Controller

This block is the digital control core of a one-to-four two-wire bus multiplexer with capacitance buffering. It decides when the common input side may be joined to each downstream channel, and when the buffers and the rising-edge accelerators may run. Its inputs are a primary-supply-good flag, a secondary-supply-above-threshold flag, one enable pin per channel, and a fault flag and a disconnect request from the stuck-bus fault block. Its outputs are one connect strobe per channel, an input-side accelerator enable, one output-side accelerator enable per channel, a buffer enable and a gate-supply select. The analog parts are outside the block and are modelled only as these logic signals.

The supply flags and the enables pass through two-flop synchronizers. Timing comes from the parameters `CLK_MHZ` and `HOLD_US`, so the hold-off lasts `HOLD_CYC = CLK_MHZ * HOLD_US` cycles.

The state machine has five states. DOWN: the primary supply is not good. HOLD: the hold-off timer is counting. LIVE: the enables drive the connections. TRIP: the block is disconnected after a fault. REARM: the fault has cleared and the block waits for every enable to be released. The transitions are:
- A low synchronized primary flag sends any state to DOWN.
- DOWN goes to HOLD once the primary flag is high.
- An edge on the synchronized secondary flag sends HOLD, LIVE, TRIP or REARM to HOLD and restarts the timer.
- HOLD goes to LIVE when the timer expires, or to TRIP if a disconnect is pending.
- LIVE goes to TRIP on a disconnect request.
- TRIP goes to REARM once the fault flag and the disconnect request are both low.
- REARM goes to LIVE when all enables are low, and back to TRIP on a new disconnect request.

Top module: `twb_mux_ctrl`

## Requirements
- R1: While reset is asserted, every output is 0: no connect strobe, no accelerator, no buffer enable, and gate select 0.
- R2: After the primary-supply-good input rises, all outputs that connect or accelerate stay at 0 for exactly `HOLD_CYC` cycles, and the channel enables are ignored during that time. With the enables already settled, a channel connects on the clock edge that is `HOLD_CYC + 3` edges after the input rises.
- R3: Any edge of the secondary-supply input closes every channel. The edge reaches the state register 3 edges after the input changes. The hold-off timer then starts again from zero, even if a hold-off was already running, so connection resumes `HOLD_CYC + 3` edges after the most recent edge.
- R4: In LIVE, `conn_o[i]` equals synchronized enable i, where bit i is channel i. `buf_en_o` and `acc_in_o` are 1 exactly when at least one enable is high. The outputs follow an enable change within 2 clock edges.
- R5: While the synchronized secondary-supply flag is 0, `acc_out_o` is all zeros, even on connected channels. When the flag is 1, `acc_out_o` equals `conn_o`.
- R6: `gate_sel_o` is 1 (the secondary supply) when the synchronized secondary flag is 1, and 0 (the primary supply) otherwise.
- R7: A disconnect request sampled high opens every channel on the next cycle.
- R8: After the fault clears, channels stay open while any enable is high. Once all enables have been seen low, the channels follow the enables again.
- R9: A falling primary-supply-good input opens all channels within 3 edges and returns the block to DOWN. A full hold-off follows when the input rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_good_i | input | 1 | Primary supply good (asynchronous) |
| sec_ok_i | input | 1 | Secondary supply above threshold (asynchronous) |
| en_i | input | NCH | Channel enable pins (asynchronous) |
| fault_i | input | 1 | Stuck-bus fault flag from the fault block |
| disc_req_i | input | 1 | Disconnect request from the fault block |
| conn_o | output | NCH | Per-channel connect strobe |
| acc_in_o | output | 1 | Input-side rise accelerator enable |
| acc_out_o | output | NCH | Per-channel output-side rise accelerator enable |
| buf_en_o | output | 1 | Buffer enable |
| gate_sel_o | output | 1 | Gate supply select: 1 selects the secondary supply, 0 the primary |

## Verification
The assertions assume that `fault_i` and `disc_req_i` are synchronous to `clk`. They also assume that the supply flags and the enables are held steady for at least a few cycles, so that each change is seen cleanly through the synchronizers. The stimulus drives every input on the falling clock edge. It holds each value for at least three edges before it samples, and it raises a disconnect request only as a one-cycle pulse while the fault flag is high. The secondary flag is toggled only at least fifty cycles apart, so each restart of the hold-off can be told apart from the one before it.

// File: rtl/twbm_pkg.sv
package twbm_pkg;

    typedef enum logic [2:0] {
        ST_DOWN  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_LIVE  = 3'd2,
        ST_TRIP  = 3'd3,
        ST_REARM = 3'd4
    } twbm_state_e;

endpackage

// File: rtl/twbm_sync.sv
module twbm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta;
    logic [W-1:0] stab;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta[g] <= 1'b0;
                    stab[g] <= 1'b0;
                end else begin
                    meta[g] <= d_i[g];
                    stab[g] <= meta[g];
                end
            end
        end
    endgenerate

    assign q_o = stab;

endmodule

// File: rtl/twbm_holdoff.sv
module twbm_holdoff #(
    parameter int HOLD_CYC = 110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic done_o
);

    localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr_i) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done_o = !clr_i && (cnt == LAST);

endmodule

// File: rtl/twbm_rearm.sv
module twbm_rearm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (set_i) begin
            pend_o <= 1'b1;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end
    end

endmodule

// File: rtl/twb_mux_ctrl.sv
module twb_mux_ctrl
    import twbm_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CLK_MHZ = 100,
    parameter int HOLD_US = 110
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pri_good_i,
    input  logic           sec_ok_i,
    input  logic [NCH-1:0] en_i,
    input  logic           fault_i,
    input  logic           disc_req_i,
    output logic [NCH-1:0] conn_o,
    output logic           acc_in_o,
    output logic [NCH-1:0] acc_out_o,
    output logic           buf_en_o,
    output logic           gate_sel_o
);

    localparam int HOLD_CYC = CLK_MHZ * HOLD_US;
    localparam int SW       = NCH + 2;

    logic [SW-1:0]  sync_q;
    logic           pri_s;
    logic           sec_s;
    logic           sec_d;
    logic [NCH-1:0] en_s;
    logic           sec_edge;
    logic           en_none;
    logic           tmr_clr;
    logic           tmr_done;
    logic           pend;
    logic           pend_clr;

    twbm_state_e st, nxt;

    twbm_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({pri_good_i, sec_ok_i, en_i}),
        .q_o   (sync_q)
    );

    assign pri_s = sync_q[SW-1];
    assign sec_s = sync_q[SW-2];
    assign en_s  = sync_q[NCH-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_d <= 1'b0;
        else        sec_d <= sec_s;
    end

    assign sec_edge = (sec_s != sec_d);
    assign en_none  = (en_s == '0);

    assign tmr_clr = (st != ST_HOLD) || sec_edge;

    twbm_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .done_o (tmr_done)
    );

    assign pend_clr = (st == ST_DOWN) || ((st == ST_REARM) && en_none);

    twbm_rearm u_rearm (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (disc_req_i && pri_s),
        .clr_i  (pend_clr),
        .pend_o (pend)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_DOWN;
        else        st <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        if (!pri_s) begin
            nxt = ST_DOWN;
        end else begin
            unique case (st)
                ST_DOWN:  nxt = ST_HOLD;
                ST_HOLD: begin
                    if (tmr_done) nxt = (pend || disc_req_i) ? ST_TRIP : ST_LIVE;
                end
                ST_LIVE: begin
                    if (sec_edge)        nxt = ST_HOLD;
                    else if (disc_req_i) nxt = ST_TRIP;
                end
                ST_TRIP: begin
                    if (sec_edge)                      nxt = ST_HOLD;
                    else if (!fault_i && !disc_req_i)  nxt = ST_REARM;
                end
                ST_REARM: begin
                    if (sec_edge)        nxt = ST_HOLD;
                    else if (disc_req_i) nxt = ST_TRIP;
                    else if (en_none)    nxt = ST_LIVE;
                end
                default: nxt = ST_DOWN;
            endcase
        end
    end

    // Output logic
    always_comb begin
        conn_o     = '0;
        acc_in_o   = 1'b0;
        acc_out_o  = '0;
        buf_en_o   = 1'b0;
        gate_sel_o = sec_s;
        if (st == ST_LIVE) begin
            conn_o    = en_s;
            acc_in_o  = !en_none;
            buf_en_o  = !en_none;
            acc_out_o = en_s & {NCH{sec_s}};
        end
    end

endmodule

// File: rtl/twb_mux_ctrl_chk.sv
module twb_mux_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           disc_req_i,
    input logic [NCH-1:0] conn_o,
    input logic           acc_in_o,
    input logic [NCH-1:0] acc_out_o,
    input logic           buf_en_o,
    input logic           gate_sel_o
);

    // R4
    conn_needs_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_o != '0) |-> (buf_en_o && acc_in_o));

    // R5
    acc_only_on_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_out_o & ~conn_o) == '0);

    // R5
    no_out_acc_low_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_sel_o |-> (acc_out_o == '0));

    // R3
    sec_change_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_sel_o) || $fell(gate_sel_o)) |=> (conn_o == '0));

    // R7
    disc_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disc_req_i |=> (conn_o == '0));

endmodule

bind twb_mux_ctrl twb_mux_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disc_req_i (disc_req_i),
    .conn_o     (conn_o),
    .acc_in_o   (acc_in_o),
    .acc_out_o  (acc_out_o),
    .buf_en_o   (buf_en_o),
    .gate_sel_o (gate_sel_o)
);

// File: tb/sim_twb_mux_ctrl.sv
`timescale 1ns/1ps
module sim_twb_mux_ctrl;

    localparam int NCH  = 4;
    localparam int HOLD = 110;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           pri_good_i;
    logic           sec_ok_i;
    logic [NCH-1:0] en_i;
    logic           fault_i;
    logic           disc_req_i;
    logic [NCH-1:0] conn_o;
    logic           acc_in_o;
    logic [NCH-1:0] acc_out_o;
    logic           buf_en_o;
    logic           gate_sel_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    twb_mux_ctrl #(.NCH(NCH), .CLK_MHZ(1), .HOLD_US(HOLD)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pri_good_i (pri_good_i),
        .sec_ok_i   (sec_ok_i),
        .en_i       (en_i),
        .fault_i    (fault_i),
        .disc_req_i (disc_req_i),
        .conn_o     (conn_o),
        .acc_in_o   (acc_in_o),
        .acc_out_o  (acc_out_o),
        .buf_en_o   (buf_en_o),
        .gate_sel_o (gate_sel_o)
    );

    // {enable, expected conn, expected any}
    localparam logic [8:0] VEC [6] = '{
        {4'b0001, 4'b0001, 1'b1},
        {4'b0110, 4'b0110, 1'b1},
        {4'b1111, 4'b1111, 1'b1},
        {4'b0000, 4'b0000, 1'b0},
        {4'b1000, 4'b1000, 1'b1},
        {4'b1010, 4'b1010, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pri_good_i = 1'b0; sec_ok_i = 1'b1;
        en_i = 4'b0011; fault_i = 1'b0; disc_req_i = 1'b0;
        edges(4);
        // R1: reset state
        check("R1 conn", conn_o, 0);
        check("R1 misc", {acc_in_o, acc_out_o, buf_en_o, gate_sel_o}, 0);
        rst_n = 1'b1;
        edges(8);
        check("R2 down", conn_o, 0);

        // R2: hold-off length after primary supply rises
        pri_good_i = 1'b1;
        edges(HOLD + 2);
        check("R2 still held", {conn_o, buf_en_o, acc_in_o}, 0);
        edges(1);
        check("R2 connect", conn_o, 4'b0011);
        check("R6 secondary", gate_sel_o, 1);

        // R4: vector walk
        for (int i = 0; i < 6; i++) begin
            en_i = VEC[i][8:5];
            edges(3);
            check("R4 conn", conn_o, VEC[i][4:1]);
            check("R4 buf/acc_in", {buf_en_o, acc_in_o}, {VEC[i][0], VEC[i][0]});
            check("R5 acc_out", acc_out_o, VEC[i][4:1]);
        end

        // R3: secondary toggle restarts hold-off
        en_i = 4'b0101;
        edges(3);
        sec_ok_i = 1'b0;
        edges(3);
        check("R3 opened", conn_o, 0);
        check("R6 primary", gate_sel_o, 0);
        edges(50);
        sec_ok_i = 1'b1;
        edges(HOLD + 2);
        check("R3 restarted", conn_o, 0);
        edges(1);
        check("R3 reconnect", conn_o, 4'b0101);

        // R5: secondary low, connection stays but output accelerators off
        sec_ok_i = 1'b0;
        edges(HOLD + 10);
        check("R5 conn", conn_o, 4'b0101);
        check("R5 acc_out off", acc_out_o, 0);
        check("R5 acc_in", acc_in_o, 1);
        sec_ok_i = 1'b1;
        edges(HOLD + 10);
        check("R5 acc_out on", acc_out_o, 4'b0101);

        // R7 / R8: fault disconnect and re-arm
        en_i = 4'b0011;
        edges(3);
        check("R4 pre-fault", conn_o, 4'b0011);
        fault_i = 1'b1; disc_req_i = 1'b1;
        edges(1);
        disc_req_i = 1'b0;
        check("R7 opened", conn_o, 0);
        edges(10);
        check("R7 held open", conn_o, 0);
        fault_i = 1'b0;
        edges(10);
        check("R8 refused enables high", conn_o, 0);
        en_i = 4'b0001;
        edges(10);
        check("R8 refused partial", conn_o, 0);
        en_i = 4'b0000;
        edges(5);
        en_i = 4'b0110;
        edges(5);
        check("R8 reconnect", conn_o, 4'b0110);

        // R9: primary supply loss
        pri_good_i = 1'b0;
        edges(3);
        check("R9 opened", {conn_o, buf_en_o}, 0);
        pri_good_i = 1'b1;
        edges(HOLD + 2);
        check("R9 hold", conn_o, 0);
        edges(1);
        check("R9 reconnect", conn_o, 4'b0110);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule